// File: doc/BRIEF.md
# Register-Windowed AXI4-Lite Master Bridge

This block gives a host that only has a narrow 16-bit register port a way to run single 32-bit transactions on an internal AXI4-Lite bus. The host sees eight 16-bit words. It loads a 32-bit target address and, for writes, a 32-bit data word as pairs of halves. It then writes a command code into the control word. The bridge runs exactly one AXI4-Lite read or write and reports how it ended through sticky event flags and an interrupt line.

A read that completes puts its 32-bit result into two read-back words. The post-increment command variants step the stored address after an OKAY response, so a run of consecutive words needs only one command write per word. A handshake that stalls longer than a programmable cycle limit is abandoned and flagged as a timeout. The downstream interrupt input is captured as a further sticky event.

Top module: `regwin_axil_bridge`

## Requirements
- R1: Host word offsets: 0 status, 1 control, 2 address low, 3 address high, 4 write data low, 5 write data high, 6 read data low, 7 read data high. The address and write-data words read back the value last written.
- R2: A transaction drives address {word3, word2} and write data {word5, word4} on the bus, always with all four byte strobes set and protection bits zero. A write that completes OKAY stores that data at that address.
- R3: The command field is control bits 3:0. 0x8 is a write, 0x9 a write with post-increment, 0xA a read and 0xB a read with post-increment. Any other code, including 0x0, starts nothing.
- R4: A read with an OKAY response places data bits 15:0 in word 6 and bits 31:16 in word 7.
- R5: Status bits 15 (read done), 14 (write done), 13 (timeout), 12 (error) and 11 (downstream interrupt) are sticky. Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R6: A nonzero BRESP or RRESP (for example SLVERR or DECERR) sets status bit 12 and does not set the matching done bit.
- R7: If a request or response phase makes no progress for TIMEOUT_CYCLES cycles, the bridge sets status bit 13, drops the transaction and returns to idle.
- R8: The post-increment commands add ADDR_STEP (default 4) to the stored address, and only after an OKAY response.
- R9: Status bit 6 is high while a transaction is in flight. A command written while it is high is ignored.
- R10: Status bit 5 rises INIT_CYCLES cycles after reset. Commands written before that are ignored.
- R11: Status bit 7 is set by an OKAY read. It is cleared when the host reads word 7 or starts a new read.
- R12: Control bits 15:11 are interrupt enables and read back as written, with the other control bits reading 0. irq_o is the OR over bits 15:11 of each status event ANDed with its enable.
- R13: While axi_irq_i is high, status bit 11 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hw_en | input | 1 | Host access strobe, one cycle per access |
| hw_we | input | 1 | Host access is a write |
| hw_addr | input | 3 | Host word offset |
| hw_wdata | input | 16 | Host write data |
| hw_rdata | output | 16 | Host read data for hw_addr (combinational) |
| axi_irq_i | input | 1 | Interrupt from the downstream AXI side |
| irq_o | output | 1 | Enabled-event interrupt |
| m_awaddr | output | 32 | Write address |
| m_awprot | output | 3 | Write protection (zero) |
| m_awvalid | output | 1 | Write address valid |
| m_awready | input | 1 | Write address ready |
| m_wdata | output | 32 | Write data |
| m_wstrb | output | 4 | Write strobes (all set) |
| m_wvalid | output | 1 | Write data valid |
| m_wready | input | 1 | Write data ready |
| m_bresp | input | 2 | Write response |
| m_bvalid | input | 1 | Write response valid |
| m_bready | output | 1 | Write response ready |
| m_araddr | output | 32 | Read address |
| m_arprot | output | 3 | Read protection (zero) |
| m_arvalid | output | 1 | Read address valid |
| m_arready | input | 1 | Read address ready |
| m_rdata | input | 32 | Read data |
| m_rresp | input | 2 | Read response |
| m_rvalid | input | 1 | Read data valid |
| m_rready | output | 1 | Read data ready |

## Verification
The bench builds the bridge with TIMEOUT_CYCLES set to 32 and INIT_CYCLES set to 3, and leaves ADDR_STEP at 4. The short stall limit lets a held-off read reach the timeout abort in a few dozen cycles. The short start-up delay lets the bench issue a command inside the not-yet-initialized window and then watch status bit 5 rise. The bench's slave model answers with SLVERR on writes and DECERR on reads in one address window, and it can hold off all ready signals. That is how the error, timeout and busy-rejection paths are reached.

// File: rtl/regwin_pkg.sv
package regwin_pkg;

   localparam logic [2:0] OFS_STAT  = 3'd0;
   localparam logic [2:0] OFS_CTRL  = 3'd1;
   localparam logic [2:0] OFS_AD_LO = 3'd2;
   localparam logic [2:0] OFS_AD_HI = 3'd3;
   localparam logic [2:0] OFS_WD_LO = 3'd4;
   localparam logic [2:0] OFS_WD_HI = 3'd5;
   localparam logic [2:0] OFS_RD_LO = 3'd6;
   localparam logic [2:0] OFS_RD_HI = 3'd7;

   // event field occupies bits EV_TOP..EV_BOT of status and control
   localparam int EV_TOP  = 15;
   localparam int EV_BOT  = 11;
   localparam int FL_RDAV = 7;
   localparam int FL_BUSY = 6;
   localparam int FL_INIT = 5;

   localparam logic [3:0] CMD_WR     = 4'h8;
   localparam logic [3:0] CMD_WR_INC = 4'h9;
   localparam logic [3:0] CMD_RD     = 4'hA;
   localparam logic [3:0] CMD_RD_INC = 4'hB;

   typedef enum logic [2:0] {
      ENG_IDLE,
      ENG_WREQ,
      ENG_WRSP,
      ENG_RREQ,
      ENG_RRSP
   } eng_st_e;

   typedef struct packed {
      logic rd_ok;
      logic wr_ok;
      logic tmo;
      logic err;
   } result_t;

endpackage

// File: rtl/regwin_init.sv
module regwin_init #(
   parameter int INIT_CYCLES = 8
) (
   input  logic clk,
   input  logic rst_n,
   output logic done
);
   localparam int CW = (INIT_CYCLES > 1) ? $clog2(INIT_CYCLES + 1) : 1;

   generate
      if (INIT_CYCLES == 0) begin : g_none
         assign done = 1'b1;
      end else begin : g_cnt
         logic [CW-1:0] cnt;
         always_ff @(posedge clk) begin
            if (!rst_n)
               cnt <= '0;
            else if (cnt != CW'(INIT_CYCLES))
               cnt <= cnt + 1'b1;
         end
         assign done = (cnt == CW'(INIT_CYCLES));
      end
   endgenerate
endmodule

// File: rtl/regwin_axi_engine.sv
module regwin_axi_engine
   import regwin_pkg::*;
#(
   parameter int AW             = 32,
   parameter int DW             = 32,
   parameter int TIMEOUT_CYCLES = 1024
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          start_rd,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   output logic          busy,
   output result_t       res,
   output logic [DW-1:0] rd_word,
   output logic [AW-1:0] m_awaddr,
   output logic          m_awvalid,
   input  logic          m_awready,
   output logic [DW-1:0] m_wdata,
   output logic          m_wvalid,
   input  logic          m_wready,
   input  logic [1:0]    m_bresp,
   input  logic          m_bvalid,
   output logic          m_bready,
   output logic [AW-1:0] m_araddr,
   output logic          m_arvalid,
   input  logic          m_arready,
   input  logic [DW-1:0] m_rdata,
   input  logic [1:0]    m_rresp,
   input  logic          m_rvalid,
   output logic          m_rready
);
   localparam int TW = (TIMEOUT_CYCLES > 1) ? $clog2(TIMEOUT_CYCLES) : 1;

   eng_st_e       st, st_n;
   logic          awp, wp, awp_n, wp_n;
   logic          adv, tmo_hit;
   logic [AW-1:0] a_q;
   logic [DW-1:0] d_q;
   result_t       hs_res;

   always_comb begin
      st_n   = st;
      awp_n  = awp;
      wp_n   = wp;
      adv    = 1'b0;
      hs_res = '0;
      case (st)
         ENG_IDLE: if (start) begin
            st_n  = start_rd ? ENG_RREQ : ENG_WREQ;
            awp_n = !start_rd;
            wp_n  = !start_rd;
            adv   = 1'b1;
         end
         ENG_WREQ: begin
            if (m_awvalid && m_awready) awp_n = 1'b0;
            if (m_wvalid && m_wready)   wp_n  = 1'b0;
            if (!awp_n && !wp_n) begin
               st_n = ENG_WRSP;
               adv  = 1'b1;
            end
         end
         ENG_WRSP: if (m_bvalid) begin
            hs_res.wr_ok = (m_bresp == 2'b00);
            hs_res.err   = (m_bresp != 2'b00);
            st_n = ENG_IDLE;
            adv  = 1'b1;
         end
         ENG_RREQ: if (m_arready) begin
            st_n = ENG_RRSP;
            adv  = 1'b1;
         end
         ENG_RRSP: if (m_rvalid) begin
            hs_res.rd_ok = (m_rresp == 2'b00);
            hs_res.err   = (m_rresp != 2'b00);
            st_n = ENG_IDLE;
            adv  = 1'b1;
         end
         default: st_n = ENG_IDLE;
      endcase
   end

   generate
      if (TIMEOUT_CYCLES > 0) begin : g_tmo
         logic [TW-1:0] tcnt;
         always_ff @(posedge clk) begin
            if (!rst_n || st == ENG_IDLE || adv)
               tcnt <= '0;
            else
               tcnt <= tcnt + 1'b1;
         end
         assign tmo_hit = (st != ENG_IDLE) && !adv && (tcnt == TW'(TIMEOUT_CYCLES - 1));
      end else begin : g_no_tmo
         assign tmo_hit = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st  <= ENG_IDLE;
         awp <= 1'b0;
         wp  <= 1'b0;
         a_q <= '0;
         d_q <= '0;
      end else begin
         st  <= tmo_hit ? ENG_IDLE : st_n;
         awp <= awp_n;
         wp  <= wp_n;
         if (st == ENG_IDLE && start) begin
            a_q <= addr;
            d_q <= wdata;
         end
      end
   end

   assign res       = '{rd_ok: hs_res.rd_ok, wr_ok: hs_res.wr_ok, tmo: tmo_hit, err: hs_res.err};
   assign busy      = (st != ENG_IDLE);
   assign rd_word   = m_rdata;
   assign m_awaddr  = a_q;
   assign m_araddr  = a_q;
   assign m_wdata   = d_q;
   assign m_awvalid = (st == ENG_WREQ) && awp;
   assign m_wvalid  = (st == ENG_WREQ) && wp;
   assign m_bready  = (st == ENG_WRSP);
   assign m_arvalid = (st == ENG_RREQ);
   assign m_rready  = (st == ENG_RRSP);
endmodule

// File: rtl/regwin_regs.sv
module regwin_regs
   import regwin_pkg::*;
#(
   parameter int HW        = 16,
   parameter int AW        = 32,
   parameter int DW        = 32,
   parameter int ADDR_STEP = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          hw_en,
   input  logic          hw_we,
   input  logic [2:0]    hw_addr,
   input  logic [HW-1:0] hw_wdata,
   output logic [HW-1:0] hw_rdata,
   input  logic          axi_irq_i,
   input  logic          init_done,
   input  logic          busy,
   input  result_t       res,
   input  logic [DW-1:0] rd_word,
   output logic          start,
   output logic          start_rd,
   output logic [AW-1:0] addr_o,
   output logic [DW-1:0] wdata_o,
   output logic          irq_o,
   output logic [4:0]    ev_o
);
   localparam int NEV = EV_TOP - EV_BOT + 1;

   logic [NEV-1:0] ev_q, en_q, ev_set, ev_clr;
   logic [AW-1:0]  addr_q;
   logic [DW-1:0]  wd_q, rd_q;
   logic           rdav_q, inc_q;
   logic           host_wr, host_rd, cmd_ok, res_ok;
   logic [3:0]     cmd;

   assign host_wr = hw_en && hw_we;
   assign host_rd = hw_en && !hw_we;
   assign cmd     = hw_wdata[3:0];
   assign cmd_ok  = (cmd == CMD_WR) || (cmd == CMD_WR_INC) ||
                    (cmd == CMD_RD) || (cmd == CMD_RD_INC);
   assign start    = host_wr && (hw_addr == OFS_CTRL) && cmd_ok && !busy && init_done;
   assign start_rd = cmd[1];
   assign res_ok   = res.rd_ok || res.wr_ok;

   assign ev_set = {res.rd_ok, res.wr_ok, res.tmo, res.err, axi_irq_i};
   assign ev_clr = (host_wr && hw_addr == OFS_STAT) ? hw_wdata[EV_TOP:EV_BOT] : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ev_q   <= '0;
         en_q   <= '0;
         addr_q <= '0;
         wd_q   <= '0;
         rd_q   <= '0;
         rdav_q <= 1'b0;
         inc_q  <= 1'b0;
      end else begin
         ev_q <= (ev_q & ~ev_clr) | ev_set;
         if (host_wr && hw_addr == OFS_CTRL)
            en_q <= hw_wdata[EV_TOP:EV_BOT];
         if (start)
            inc_q <= cmd[0];
         if (host_wr && hw_addr == OFS_AD_LO)
            addr_q[HW-1:0] <= hw_wdata;
         else if (host_wr && hw_addr == OFS_AD_HI)
            addr_q[AW-1:HW] <= hw_wdata;
         else if (res_ok && inc_q)
            addr_q <= addr_q + AW'(ADDR_STEP);
         if (host_wr && hw_addr == OFS_WD_LO)
            wd_q[HW-1:0] <= hw_wdata;
         if (host_wr && hw_addr == OFS_WD_HI)
            wd_q[DW-1:HW] <= hw_wdata;
         if (res.rd_ok)
            rd_q <= rd_word;
         if (res.rd_ok)
            rdav_q <= 1'b1;
         else if ((start && start_rd) || (host_rd && hw_addr == OFS_RD_HI))
            rdav_q <= 1'b0;
      end
   end

   always_comb begin
      hw_rdata = '0;
      case (hw_addr)
         OFS_STAT: begin
            hw_rdata[EV_TOP:EV_BOT] = ev_q;
            hw_rdata[FL_RDAV]       = rdav_q;
            hw_rdata[FL_BUSY]       = busy;
            hw_rdata[FL_INIT]       = init_done;
         end
         OFS_CTRL:  hw_rdata[EV_TOP:EV_BOT] = en_q;
         OFS_AD_LO: hw_rdata = addr_q[HW-1:0];
         OFS_AD_HI: hw_rdata = addr_q[AW-1:HW];
         OFS_WD_LO: hw_rdata = wd_q[HW-1:0];
         OFS_WD_HI: hw_rdata = wd_q[DW-1:HW];
         OFS_RD_LO: hw_rdata = rd_q[HW-1:0];
         default:   hw_rdata = rd_q[DW-1:HW];
      endcase
   end

   assign irq_o   = |(ev_q & en_q);
   assign addr_o  = addr_q;
   assign wdata_o = wd_q;
   assign ev_o    = ev_q;
endmodule

// File: rtl/regwin_axil_bridge.sv
module regwin_axil_bridge
   import regwin_pkg::*;
#(
   parameter int HOST_W         = 16,
   parameter int AXI_AW         = 32,
   parameter int AXI_DW         = 32,
   parameter int TIMEOUT_CYCLES = 1024,
   parameter int INIT_CYCLES    = 8,
   parameter int ADDR_STEP      = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hw_en,
   input  logic              hw_we,
   input  logic [2:0]        hw_addr,
   input  logic [HOST_W-1:0] hw_wdata,
   output logic [HOST_W-1:0] hw_rdata,
   input  logic              axi_irq_i,
   output logic              irq_o,
   output logic [AXI_AW-1:0] m_awaddr,
   output logic [2:0]        m_awprot,
   output logic              m_awvalid,
   input  logic              m_awready,
   output logic [AXI_DW-1:0] m_wdata,
   output logic [AXI_DW/8-1:0] m_wstrb,
   output logic              m_wvalid,
   input  logic              m_wready,
   input  logic [1:0]        m_bresp,
   input  logic              m_bvalid,
   output logic              m_bready,
   output logic [AXI_AW-1:0] m_araddr,
   output logic [2:0]        m_arprot,
   output logic              m_arvalid,
   input  logic              m_arready,
   input  logic [AXI_DW-1:0] m_rdata,
   input  logic [1:0]        m_rresp,
   input  logic              m_rvalid,
   output logic              m_rready
);
   generate
      if (AXI_AW != 2 * HOST_W) begin : g_bad_aw
         $error("AXI_AW must be twice HOST_W");
      end
      if (AXI_DW != 2 * HOST_W) begin : g_bad_dw
         $error("AXI_DW must be twice HOST_W");
      end
      if (HOST_W != EV_TOP + 1) begin : g_bad_hw
         $error("HOST_W must match the status word width");
      end
      if (ADDR_STEP <= 0) begin : g_bad_step
         $error("ADDR_STEP must be positive");
      end
   endgenerate

   logic              init_done, eng_busy, start, start_rd, tmo_pulse;
   result_t           eng_res;
   logic [AXI_AW-1:0] cur_addr;
   logic [AXI_DW-1:0] cur_wdata, rd_word;
   logic [4:0]        ev_vec;

   regwin_init #(.INIT_CYCLES(INIT_CYCLES)) u_init (
      .clk(clk), .rst_n(rst_n), .done(init_done)
   );

   regwin_regs #(
      .HW(HOST_W), .AW(AXI_AW), .DW(AXI_DW), .ADDR_STEP(ADDR_STEP)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .hw_en(hw_en), .hw_we(hw_we), .hw_addr(hw_addr),
      .hw_wdata(hw_wdata), .hw_rdata(hw_rdata),
      .axi_irq_i(axi_irq_i), .init_done(init_done), .busy(eng_busy),
      .res(eng_res), .rd_word(rd_word),
      .start(start), .start_rd(start_rd),
      .addr_o(cur_addr), .wdata_o(cur_wdata), .irq_o(irq_o), .ev_o(ev_vec)
   );

   regwin_axi_engine #(
      .AW(AXI_AW), .DW(AXI_DW), .TIMEOUT_CYCLES(TIMEOUT_CYCLES)
   ) u_eng (
      .clk(clk), .rst_n(rst_n),
      .start(start), .start_rd(start_rd), .addr(cur_addr), .wdata(cur_wdata),
      .busy(eng_busy), .res(eng_res), .rd_word(rd_word),
      .m_awaddr(m_awaddr), .m_awvalid(m_awvalid), .m_awready(m_awready),
      .m_wdata(m_wdata), .m_wvalid(m_wvalid), .m_wready(m_wready),
      .m_bresp(m_bresp), .m_bvalid(m_bvalid), .m_bready(m_bready),
      .m_araddr(m_araddr), .m_arvalid(m_arvalid), .m_arready(m_arready),
      .m_rdata(m_rdata), .m_rresp(m_rresp), .m_rvalid(m_rvalid), .m_rready(m_rready)
   );

   assign tmo_pulse = eng_res.tmo;
   assign m_awprot  = 3'b000;
   assign m_arprot  = 3'b000;
   assign m_wstrb   = '1;
endmodule

// File: rtl/regwin_axil_bridge_chk.sv
module regwin_axil_bridge_chk #(
   parameter int AW = 32,
   parameter int SW = 4
) (
   input logic          clk,
   input logic          rst_n,
   input logic          hw_en,
   input logic          hw_we,
   input logic [2:0]    hw_addr,
   input logic          m_awvalid,
   input logic          m_wvalid,
   input logic [SW-1:0] m_wstrb,
   input logic          m_bready,
   input logic [AW-1:0] m_araddr,
   input logic          m_arvalid,
   input logic          m_arready,
   input logic          m_rready,
   input logic          busy,
   input logic          tmo_pulse,
   input logic          init_done,
   input logic [4:0]    ev
);
   // R9: one transaction at a time, never both address channels
   a_r9_one_channel: assert property (@(posedge clk) disable iff (!rst_n)
      !(m_arvalid && m_awvalid));

   // R2: full-word strobes on every write beat
   a_r2_full_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      m_wvalid |-> (m_wstrb == '1));

   // R9: any bus activity implies the busy flag
   a_r9_busy_covers_bus: assert property (@(posedge clk) disable iff (!rst_n)
      (m_arvalid || m_awvalid || m_wvalid || m_bready || m_rready) |-> busy);

   // R7: a timeout returns the engine to idle on the next cycle
   a_r7_abort_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
      tmo_pulse |=> !busy);

   // R5: read-done event stays set unless the host writes the status word
   a_r5_sticky_rd: assert property (@(posedge clk) disable iff (!rst_n)
      (ev[4] && !(hw_en && hw_we && hw_addr == 3'd0)) |=> ev[4]);

   // R3: a pending read address is held until accepted or aborted
   a_r3_ar_held: assert property (@(posedge clk) disable iff (!rst_n)
      (m_arvalid && !m_arready && !tmo_pulse) |=> (m_arvalid && $stable(m_araddr)));

   // R10: nothing runs before initialization completes
   a_r10_idle_before_init: assert property (@(posedge clk) disable iff (!rst_n)
      !init_done |-> !busy);
endmodule

bind regwin_axil_bridge regwin_axil_bridge_chk #(.AW(AXI_AW), .SW(AXI_DW/8)) u_chk (
   .clk(clk), .rst_n(rst_n), .hw_en(hw_en), .hw_we(hw_we), .hw_addr(hw_addr),
   .m_awvalid(m_awvalid), .m_wvalid(m_wvalid), .m_wstrb(m_wstrb), .m_bready(m_bready),
   .m_araddr(m_araddr), .m_arvalid(m_arvalid), .m_arready(m_arready), .m_rready(m_rready),
   .busy(eng_busy), .tmo_pulse(tmo_pulse), .init_done(init_done), .ev(ev_vec)
);

// File: tb/regwin_axil_bridge_bench.sv
module regwin_axil_bridge_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        hw_en = 1'b0, hw_we = 1'b0;
   logic [2:0]  hw_addr = '0;
   logic [15:0] hw_wdata = '0, hw_rdata;
   logic        axi_irq_i = 1'b0, irq_o;
   logic [31:0] m_awaddr, m_wdata, m_araddr, m_rdata;
   logic [2:0]  m_awprot, m_arprot;
   logic [3:0]  m_wstrb;
   logic        m_awvalid, m_awready, m_wvalid, m_wready, m_bvalid, m_bready;
   logic        m_arvalid, m_arready, m_rvalid, m_rready;
   logic [1:0]  m_bresp, m_rresp;

   int n_chk = 0, n_fail = 0;

   always #10 clk = ~clk;

   regwin_axil_bridge #(.TIMEOUT_CYCLES(32), .INIT_CYCLES(3)) u_regwin_axil_bridge (
      .clk(clk), .rst_n(rst_n), .hw_en(hw_en), .hw_we(hw_we), .hw_addr(hw_addr),
      .hw_wdata(hw_wdata), .hw_rdata(hw_rdata), .axi_irq_i(axi_irq_i), .irq_o(irq_o),
      .m_awaddr(m_awaddr), .m_awprot(m_awprot), .m_awvalid(m_awvalid), .m_awready(m_awready),
      .m_wdata(m_wdata), .m_wstrb(m_wstrb), .m_wvalid(m_wvalid), .m_wready(m_wready),
      .m_bresp(m_bresp), .m_bvalid(m_bvalid), .m_bready(m_bready),
      .m_araddr(m_araddr), .m_arprot(m_arprot), .m_arvalid(m_arvalid), .m_arready(m_arready),
      .m_rdata(m_rdata), .m_rresp(m_rresp), .m_rvalid(m_rvalid), .m_rready(m_rready)
   );

   // slave model: 16 words, addr[11:8]==F answers with an error response
   logic        stall = 1'b0;
   logic [31:0] mem [16];
   logic [31:0] last_aw, last_ar;
   logic [3:0]  last_strb;
   int          aw_cnt, ar_cnt;

   assign m_awready = m_awvalid && m_wvalid && !stall;
   assign m_wready  = m_awvalid && m_wvalid && !stall;
   assign m_arready = m_arvalid && !stall;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_bvalid <= 1'b0; m_rvalid <= 1'b0; m_bresp <= 2'b00; m_rresp <= 2'b00;
         m_rdata <= '0; aw_cnt <= 0; ar_cnt <= 0; last_aw <= '0; last_ar <= '0;
         last_strb <= '0;
         for (int i = 0; i < 16; i++) mem[i] <= '0;
      end else begin
         if (m_awvalid && m_awready) begin
            aw_cnt    <= aw_cnt + 1;
            last_aw   <= m_awaddr;
            last_strb <= m_wstrb;
            m_bvalid  <= 1'b1;
            m_bresp   <= (m_awaddr[11:8] == 4'hF) ? 2'b10 : 2'b00;
            if (m_awaddr[11:8] != 4'hF) mem[m_awaddr[5:2]] <= m_wdata;
         end else if (m_bvalid && m_bready) m_bvalid <= 1'b0;
         if (m_arvalid && m_arready) begin
            ar_cnt   <= ar_cnt + 1;
            last_ar  <= m_araddr;
            m_rvalid <= 1'b1;
            m_rresp  <= (m_araddr[11:8] == 4'hF) ? 2'b11 : 2'b00;
            m_rdata  <= mem[m_araddr[5:2]];
         end else if (m_rvalid && m_rready) m_rvalid <= 1'b0;
      end
   end

   task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", what, act, exp);
      end
   endtask

   task automatic host_wr(input logic [2:0] a, input logic [15:0] d);
      @(negedge clk);
      hw_en = 1'b1; hw_we = 1'b1; hw_addr = a; hw_wdata = d;
      @(posedge clk); #1;
      hw_en = 1'b0; hw_we = 1'b0;
   endtask

   task automatic host_rd(input logic [2:0] a, output logic [15:0] d);
      @(negedge clk);
      hw_en = 1'b1; hw_we = 1'b0; hw_addr = a;
      #1 d = hw_rdata;
      @(posedge clk); #1;
      hw_en = 1'b0;
   endtask

   task automatic wait_idle();
      logic [15:0] s;
      for (int k = 0; k < 200; k++) begin
         host_rd(3'd0, s);
         if (!s[6]) break;
      end
   endtask

   typedef struct packed {
      logic        rd;
      logic        inc;
      logic [31:0] addr;
      logic [31:0] data;
      logic [15:0] ev;
   } vec_t;

   localparam vec_t VECS [9] = '{
      '{rd:1'b0, inc:1'b0, addr:32'h0000_0010, data:32'hDEAD_BEEF, ev:16'h4000},
      '{rd:1'b0, inc:1'b1, addr:32'h0000_0020, data:32'h1234_5678, ev:16'h4000},
      '{rd:1'b1, inc:1'b0, addr:32'h0000_0010, data:32'hDEAD_BEEF, ev:16'h8000},
      '{rd:1'b1, inc:1'b1, addr:32'h0000_0020, data:32'h1234_5678, ev:16'h8000},
      '{rd:1'b0, inc:1'b0, addr:32'h0000_0F00, data:32'h5555_AAAA, ev:16'h1000},
      '{rd:1'b1, inc:1'b0, addr:32'h0000_0F00, data:32'h0000_0000, ev:16'h1000},
      '{rd:1'b0, inc:1'b1, addr:32'hABCD_0030, data:32'hCAFE_F00D, ev:16'h4000},
      '{rd:1'b1, inc:1'b0, addr:32'hABCD_0030, data:32'hCAFE_F00D, ev:16'h8000},
      '{rd:1'b0, inc:1'b1, addr:32'h0000_0F04, data:32'h0BAD_0BAD, ev:16'h1000}
   };

   task automatic run_tests();
      logic [15:0] s, lo, hi;
      int aw0, ar0;

      // reset and R10
      repeat (4) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      host_rd(3'd0, s);
      chk("R10 status before init", 32'(s), 32'h0000);
      chk("R12 irq after reset", 32'(irq_o), 32'h0);
      host_wr(3'd1, 16'h000A);
      repeat (6) @(negedge clk);
      host_rd(3'd0, s);
      chk("R10 status after init, early command dropped", 32'(s), 32'h0020);
      chk("R10 no read issued before init", 32'(ar_cnt), 32'h0);

      // R1 readback
      host_wr(3'd2, 16'h1111); host_wr(3'd3, 16'h2222);
      host_wr(3'd4, 16'h3333); host_wr(3'd5, 16'h4444);
      host_rd(3'd2, s); chk("R1 addr lo", 32'(s), 32'h1111);
      host_rd(3'd3, s); chk("R1 addr hi", 32'(s), 32'h2222);
      host_rd(3'd4, s); chk("R1 wdata lo", 32'(s), 32'h3333);
      host_rd(3'd5, s); chk("R1 wdata hi", 32'(s), 32'h4444);

      // vector table
      for (int i = 0; i < 9; i++) begin
         vec_t v;
         logic [31:0] exp_addr;
         logic ok;
         v = VECS[i];
         ok = v.ev[15] || v.ev[14];
         exp_addr = (v.inc && ok) ? v.addr + 32'd4 : v.addr;
         host_wr(3'd2, v.addr[15:0]);
         host_wr(3'd3, v.addr[31:16]);
         if (!v.rd) begin
            host_wr(3'd4, v.data[15:0]);
            host_wr(3'd5, v.data[31:16]);
         end
         host_wr(3'd1, {12'h000, 2'b10, v.rd, v.inc});
         wait_idle();
         host_rd(3'd0, s);
         chk($sformatf("R5 R6 events vec%0d", i), 32'(s[15:11]), 32'(v.ev[15:11]));
         chk($sformatf("R9 idle after vec%0d", i), 32'(s[6]), 32'h0);
         host_rd(3'd2, lo); host_rd(3'd3, hi);
         chk($sformatf("R8 address after vec%0d", i), {hi, lo}, exp_addr);
         chk($sformatf("R2 bus address vec%0d", i), v.rd ? last_ar : last_aw, v.addr);
         if (v.rd && ok) begin
            host_rd(3'd6, lo); host_rd(3'd7, hi);
            chk($sformatf("R4 read data vec%0d", i), {hi, lo}, v.data);
         end
         if (!v.rd && ok) begin
            chk($sformatf("R2 stored data vec%0d", i), mem[v.addr[5:2]], v.data);
            chk($sformatf("R2 strobes vec%0d", i), 32'(last_strb), 32'hF);
         end
         host_wr(3'd0, 16'hF800);
      end

      // R11 read-available flag
      host_wr(3'd2, 16'h0010); host_wr(3'd3, 16'h0000);
      host_wr(3'd1, 16'h000A); wait_idle();
      host_rd(3'd0, s); chk("R11 set by read", 32'(s[7]), 32'h1);
      host_rd(3'd6, s); host_rd(3'd0, s); chk("R11 kept after low word", 32'(s[7]), 32'h1);
      host_rd(3'd7, s); host_rd(3'd0, s); chk("R11 cleared by high word", 32'(s[7]), 32'h0);
      host_wr(3'd0, 16'hF800);

      // R12 interrupt enables, R5 write-zero
      host_wr(3'd1, 16'h4000);
      host_rd(3'd1, s); chk("R12 control readback", 32'(s), 32'h4000);
      chk("R12 irq without event", 32'(irq_o), 32'h0);
      host_wr(3'd2, 16'h0040); host_wr(3'd4, 16'h0001);
      host_wr(3'd1, 16'h4008); wait_idle();
      @(negedge clk); chk("R12 irq on enabled write done", 32'(irq_o), 32'h1);
      host_wr(3'd0, 16'h4000);
      @(negedge clk); chk("R12 irq drops after clear", 32'(irq_o), 32'h0);
      host_wr(3'd1, 16'h0008); wait_idle();
      @(negedge clk); chk("R12 irq masked", 32'(irq_o), 32'h0);
      host_wr(3'd0, 16'h0000);
      host_rd(3'd0, s); chk("R5 write 0 keeps event", 32'(s[14]), 32'h1);
      host_wr(3'd0, 16'h4000);
      host_rd(3'd0, s); chk("R5 write 1 clears event", 32'(s[15:11]), 32'h0);

      // R13 downstream interrupt
      @(negedge clk); axi_irq_i = 1'b1;
      @(negedge clk); axi_irq_i = 1'b0;
      host_rd(3'd0, s); chk("R13 downstream irq event", 32'(s[15:11]), 32'h01);
      host_wr(3'd1, 16'h0800);
      @(negedge clk); chk("R13 R12 irq from bit 11", 32'(irq_o), 32'h1);
      host_wr(3'd0, 16'h0800); host_wr(3'd1, 16'h0000);

      // R3 non-commands
      aw0 = aw_cnt; ar0 = ar_cnt;
      host_wr(3'd1, 16'h0000); host_wr(3'd1, 16'h0005); host_wr(3'd1, 16'h000C);
      repeat (5) @(negedge clk);
      host_rd(3'd0, s);
      chk("R3 no events for NOP or bad codes", 32'(s[15:11]), 32'h0);
      chk("R3 no bus traffic", 32'(aw_cnt + ar_cnt), 32'(aw0 + ar0));

      // R9 command while busy
      aw0 = aw_cnt;
      stall = 1'b1;
      host_wr(3'd2, 16'h0010);
      host_wr(3'd1, 16'h000A);
      host_rd(3'd0, s); chk("R9 busy during stall", 32'(s[6]), 32'h1);
      host_wr(3'd1, 16'h0008);
      @(negedge clk); stall = 1'b0;
      wait_idle(); repeat (4) @(negedge clk);
      host_rd(3'd0, s);
      chk("R9 only the first command ran", 32'(s[15:11]), 32'h10);
      chk("R9 no write issued", 32'(aw_cnt), 32'(aw0));
      host_wr(3'd0, 16'hF800);

      // R7 timeout
      ar0 = ar_cnt;
      stall = 1'b1;
      host_wr(3'd1, 16'h000A);
      repeat (45) @(negedge clk);
      host_rd(3'd0, s);
      chk("R7 timeout event only", 32'(s[15:11]), 32'h04);
      chk("R7 back to idle", 32'(s[6]), 32'h0);
      stall = 1'b0;
      repeat (3) @(negedge clk);
      chk("R7 aborted read never accepted", 32'(ar_cnt), 32'(ar0));
   endtask

   initial begin
      fork
         run_tests();
         begin
            repeat (100000) @(posedge clk);
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
         end
      join_any
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule